// File: doc/BRIEF.md
# Word Ownership Registry Bank

This block is one bank of a shared cache that doubles as the ownership registry for a set of private caches. Every word it covers is in one of two conditions. Either the bank holds the word's current value, or the word is owned by a private cache, and the bank keeps that cache's identifier in the word's data slot. A single registered flag per word records which of the two conditions holds. Each line also carries a valid flag and a dirty flag. The bank keeps no sharer lists and never sends invalidations.

Private caches send three kinds of request: reads, registrations (requests to take ownership), and write-backs that hand ownership back. Requests are served strictly one per cycle, in the order they arrive.

A registration for a word that is already owned is not answered by the bank. It is forwarded to the current owner, and the requester is recorded as the new owner at once. When several caches race for the same word, each forwarded request therefore lands at its predecessor, and the requests form a queue spread across the caches. Backing storage outside the bank is modelled as preloaded: a word in a line that has never been written reads as a fixed function of its address.

Top module: `rb_registry_bank`

## Requirements
- R1: After reset no word is owned, no response is pending, and every line is invalid. An invalid line's words read as B(a) = (a*37 + 0x1234) mod 2^DATA_W, where a is the word address.
- R2: Each accepted request that produces a response does so exactly two clock edges after it is sampled, with `rsp_addr` echoing the request address. Responses leave in request arrival order.
- R3: A read (op 0) of an unowned word returns kind 1 (data), addressed to the requester, carrying the word's current value.
- R4: A registration (op 1) of an unowned word returns kind 2 (grant) to the requester, carrying the word's current value. The requester becomes the owner.
- R5: A registration of a word owned by a different cache returns kind 4 (forwarded registration) with `rsp_dst` set to the previous owner and `rsp_requester` set to the new requester. Ownership moves to the requester at once, so a chain of registrations forwards each one to its immediate predecessor.
- R6: A read of an owned word returns kind 3 (forwarded read) to the owner, naming the requester. A read never changes ownership.
- R7: A registration from the word's current owner returns kind 2 with data zero and leaves ownership unchanged.
- R8: A write-back (op 2) from the current owner returns kind 5 (done) to that owner. It stores the written value and leaves the word unowned, so a later read returns that value.
- R9: A write-back from a cache that does not own the word, or to an unowned word, produces no response and changes neither ownership nor data.
- R10: Op code 3 produces no response and changes nothing.
- R11: Back-to-back requests to the same line or the same word each see the effect of the request just before them. Words of a line that has been written, but not the word that was written, keep their B(a) values.
- R12: Forwarded responses and kind 5 carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 registration, 2 write-back, 3 reserved |
| req_src | input | ID_W | Identifier of the requesting private cache |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write-back value |
| rsp_valid | output | 1 | Response or forward present |
| rsp_kind | output | 3 | 1 data, 2 grant, 3 forwarded read, 4 forwarded registration, 5 write-back done |
| rsp_dst | output | ID_W | Cache that receives this message |
| rsp_requester | output | ID_W | Cache that issued the original request |
| rsp_addr | output | ADDR_W | Word address of the request |
| rsp_data | output | DATA_W | Word value, or zero |

## Verification
A wrong registered flag or a wrong stored owner shows at the ports on the next request to that word. That request gets a data reply where a forward was due, or a forward goes to the wrong cache, two cycles after it is issued. A lost line update or a stale read across consecutive requests shows as a wrong `rsp_data` on the very next same-line request. For that reason the sweep touches every word with every request type, and it drives consecutive same-line requests with no gap. Dropped write-backs and reserved opcodes leave no response, so each one is followed by a read whose reply exposes any change they caused.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    OP_READ      = 2'd0,
    OP_REGISTER  = 2'd1,
    OP_WRITEBACK = 2'd2,
    OP_RSVD      = 2'd3
  } rb_op_e;

  typedef enum logic [2:0] {
    RK_NONE    = 3'd0,
    RK_DATA    = 3'd1,
    RK_GRANT   = 3'd2,
    RK_FWD_RD  = 3'd3,
    RK_FWD_REG = 3'd4,
    RK_WB_DONE = 3'd5
  } rb_kind_e;

  // Preloaded backing value of a word address.
  function automatic logic [31:0] rb_backing(input logic [31:0] a);
    return a * 32'd37 + 32'h1234;
  endfunction

endpackage

// File: rtl/rb_line_store.sv
module rb_line_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic [AW-1:0]    raddr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] mem_q;
  logic [WIDTH-1:0] wr_q;
  logic             hit_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
    hit_q <= we && (waddr == raddr);
    wr_q  <= wdata;
  end

  // A write in the same cycle as the read is returned instead of the old entry.
  assign rdata = hit_q ? wr_q : mem_q;
endmodule

// File: rtl/rb_meta.sv
module rb_meta #(
  parameter int LINES = 8,
  parameter int WPL   = 4,
  localparam int NW     = LINES * WPL,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int IDX_W  = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LINE_W-1:0] lidx,
  input  logic              set_reg,
  input  logic              clr_reg,
  input  logic              line_wr,
  input  logic              set_dirty,
  output logic [NW-1:0]     regd_q,
  output logic [LINES-1:0]  valid_q
);
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regd_q  <= '0;
      valid_q <= '0;
      dirty_q <= '0;
    end else if (upd) begin
      if (set_reg)   regd_q[widx]  <= 1'b1;
      if (clr_reg)   regd_q[widx]  <= 1'b0;
      if (line_wr)   valid_q[lidx] <= 1'b1;
      if (set_dirty) dirty_q[lidx] <= 1'b1;
    end
  end

  assert_no_set_and_clear_R9: assert property (@(posedge clk) disable iff (rst)
    upd |-> !(set_reg && clr_reg));

  assert_clear_only_owned_R8: assert property (@(posedge clk) disable iff (rst)
    (upd && clr_reg) |-> regd_q[widx]);

  assert_dirty_after_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (upd && set_dirty) |=> dirty_q[$past(lidx)]);
endmodule

// File: rtl/rb_decide.sv
module rb_decide
  import rb_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16
) (
  input  rb_op_e            op,
  input  logic [ID_W-1:0]   src,
  input  logic              regd,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output rb_kind_e          kind,
  output logic [ID_W-1:0]   dst,
  output logic [DATA_W-1:0] data,
  output logic              wr,
  output logic [DATA_W-1:0] new_word,
  output logic              set_reg,
  output logic              clr_reg,
  output logic              set_dirty
);
  logic [ID_W-1:0] owner;
  assign owner = word[ID_W-1:0];

  always_comb begin
    kind      = RK_NONE;
    dst       = src;
    data      = '0;
    wr        = 1'b0;
    new_word  = word;
    set_reg   = 1'b0;
    clr_reg   = 1'b0;
    set_dirty = 1'b0;
    unique case (op)
      OP_READ: begin
        if (regd) begin
          kind = RK_FWD_RD;
          dst  = owner;
        end else begin
          kind = RK_DATA;
          data = word;
        end
      end
      OP_REGISTER: begin
        if (regd && owner == src) begin
          kind = RK_GRANT;
        end else begin
          wr       = 1'b1;
          new_word = DATA_W'(src);
          if (regd) begin
            kind = RK_FWD_REG;
            dst  = owner;
          end else begin
            kind    = RK_GRANT;
            data    = word;
            set_reg = 1'b1;
          end
        end
      end
      OP_WRITEBACK: begin
        if (regd && owner == src) begin
          kind      = RK_WB_DONE;
          wr        = 1'b1;
          new_word  = wdata;
          clr_reg   = 1'b1;
          set_dirty = 1'b1;
        end
      end
      default: kind = RK_NONE;
    endcase
  end
endmodule

// File: rtl/rb_registry_bank.sv
module rb_registry_bank
  import rb_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  parameter int WPL    = 4,
  localparam int NW        = LINES * WPL,
  localparam int LINE_W    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WSEL_W    = $clog2(WPL),
  localparam int ADDR_W    = $clog2(NW),
  localparam int LINE_BITS = WPL * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [ID_W-1:0]   rsp_requester,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  // Stage 1: request captured while its line is read.
  logic              s1_v;
  rb_op_e            s1_op;
  logic [ID_W-1:0]   s1_src;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_op    <= OP_READ;
      s1_src   <= '0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_v     <= req_valid;
      s1_op    <= rb_op_e'(req_op);
      s1_src   <= req_src;
      s1_addr  <= req_addr;
      s1_wdata <= req_wdata;
    end
  end

  logic [LINE_W-1:0] s1_line;
  logic [WSEL_W-1:0] s1_wsel;
  assign s1_line = s1_addr[ADDR_W-1:WSEL_W];
  assign s1_wsel = s1_addr[WSEL_W-1:0];

  logic [LINE_BITS-1:0] store_q, bk_line, cur_line, new_line;
  logic [NW-1:0]        regd_q;
  logic [LINES-1:0]     valid_q;
  logic [DATA_W-1:0]    cur_word;

  rb_kind_e          d_kind;
  logic [ID_W-1:0]   d_dst;
  logic [DATA_W-1:0] d_data, d_word;
  logic              d_wr, d_set, d_clr, d_dirty;

  always_comb begin
    for (int w = 0; w < WPL; w++) begin
      bk_line[w*DATA_W +: DATA_W] =
        DATA_W'(rb_backing(32'({s1_line, WSEL_W'(w)})));
    end
  end

  assign cur_line = valid_q[s1_line] ? store_q : bk_line;
  assign cur_word = cur_line[s1_wsel*DATA_W +: DATA_W];

  always_comb begin
    new_line = cur_line;
    new_line[s1_wsel*DATA_W +: DATA_W] = d_word;
  end

  rb_line_store #(.DEPTH(LINES), .WIDTH(LINE_BITS)) u_store (
    .clk   (clk),
    .raddr (req_addr[ADDR_W-1:WSEL_W]),
    .we    (s1_v && d_wr),
    .waddr (s1_line),
    .wdata (new_line),
    .rdata (store_q)
  );

  rb_meta #(.LINES(LINES), .WPL(WPL)) u_meta (
    .clk       (clk),
    .rst       (rst),
    .upd       (s1_v),
    .widx      (s1_addr),
    .lidx      (s1_line),
    .set_reg   (d_set),
    .clr_reg   (d_clr),
    .line_wr   (d_wr),
    .set_dirty (d_dirty),
    .regd_q    (regd_q),
    .valid_q   (valid_q)
  );

  rb_decide #(.ID_W(ID_W), .DATA_W(DATA_W)) u_decide (
    .op        (s1_op),
    .src       (s1_src),
    .regd      (regd_q[s1_addr]),
    .word      (cur_word),
    .wdata     (s1_wdata),
    .kind      (d_kind),
    .dst       (d_dst),
    .data      (d_data),
    .wr        (d_wr),
    .new_word  (d_word),
    .set_reg   (d_set),
    .clr_reg   (d_clr),
    .set_dirty (d_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_kind      <= RK_NONE;
      rsp_dst       <= '0;
      rsp_requester <= '0;
      rsp_addr      <= '0;
      rsp_data      <= '0;
    end else begin
      rsp_valid     <= s1_v && (d_kind != RK_NONE);
      rsp_kind      <= d_kind;
      rsp_dst       <= d_dst;
      rsp_requester <= s1_src;
      rsp_addr      <= s1_addr;
      rsp_data      <= d_data;
    end
  end

  assert_resp_has_request_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  assert_resp_addr_order_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_addr == $past(req_addr, 2));

  assert_fwd_to_other_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RK_FWD_REG) |-> rsp_dst != rsp_requester);

  assert_read_keeps_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_op == OP_READ) |=> $stable(regd_q));

  assert_fwd_zero_data_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind inside {RK_FWD_RD, RK_FWD_REG, RK_WB_DONE}) |-> rsp_data == '0);
endmodule

// File: tb/tb_rb_registry_bank.sv
module tb_rb_registry_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4, DATA_W = 16, LINES = 8, WPL = 4;
  localparam int NW = LINES * WPL, ADDR_W = 5;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [ID_W-1:0] req_src = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [DATA_W-1:0] req_wdata = 0;
  logic rsp_valid;
  logic [2:0] rsp_kind;
  logic [ID_W-1:0] rsp_dst, rsp_requester;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DATA_W-1:0] rsp_data;

  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rb_registry_bank #(.ID_W(ID_W), .DATA_W(DATA_W), .LINES(LINES), .WPL(WPL)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_requester(rsp_requester), .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  // Requirement model: owner (-1 = none) and bank value per word.
  int own [NW];
  logic [DATA_W-1:0] val [NW];

  function automatic logic [DATA_W-1:0] bk(input int a);
    return DATA_W'(a * 37 + 'h1234);
  endfunction

  typedef struct packed {
    logic v; logic [2:0] k; logic [ID_W-1:0] d; logic [ID_W-1:0] r;
    logic [ADDR_W-1:0] a; logic [DATA_W-1:0] x;
  } exp_t;

  function automatic exp_t predict(input int op, input int src, input int a,
                                   input logic [DATA_W-1:0] wd);
    exp_t e = '0;
    e.r = ID_W'(src); e.a = ADDR_W'(a); e.d = ID_W'(src);
    case (op)
      0: if (own[a] >= 0) begin e.v = 1; e.k = 3; e.d = ID_W'(own[a]); end
         else begin e.v = 1; e.k = 1; e.x = val[a]; end
      1: if (own[a] == src) begin e.v = 1; e.k = 2; end
         else if (own[a] >= 0) begin e.v = 1; e.k = 4; e.d = ID_W'(own[a]); own[a] = src; end
         else begin e.v = 1; e.k = 2; e.x = val[a]; own[a] = src; end
      2: if (own[a] == src) begin e.v = 1; e.k = 5; own[a] = -1; val[a] = wd; end
      default: e.v = 0;
    endcase
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t got;
    got = '{rsp_valid, rsp_kind, rsp_dst, rsp_requester, rsp_addr, rsp_data};
    checks++;
    if (!e.v) begin
      if (rsp_valid) begin
        errors++;
        $display("FAIL %s: unexpected response act=%h exp=none", tag, got);
      end
    end else if (got != e) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, got, e);
    end
  endtask

  task automatic drive(input int op, input int src, input int a, input logic [DATA_W-1:0] wd);
    req_valid = 1; req_op = 2'(op); req_src = ID_W'(src);
    req_addr = ADDR_W'(a); req_wdata = wd;
  endtask

  task automatic txn(input int op, input int src, input int a,
                     input logic [DATA_W-1:0] wd, input string tag);
    exp_t e;
    e = predict(op, src, a, wd);
    @(negedge clk); drive(op, src, a, wd);
    @(negedge clk); req_valid = 0;
    @(negedge clk); compare(e, tag);
  endtask

  task automatic pair(input int op0, input int s0, input int a0, input logic [DATA_W-1:0] w0,
                      input int op1, input int s1, input int a1, input logic [DATA_W-1:0] w1,
                      input string tag);
    exp_t e0, e1;
    e0 = predict(op0, s0, a0, w0);
    e1 = predict(op1, s1, a1, w1);
    @(negedge clk); drive(op0, s0, a0, w0);
    @(negedge clk); drive(op1, s1, a1, w1);
    @(negedge clk); req_valid = 0; compare(e0, tag);
    @(negedge clk); compare(e1, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NW; a++) begin own[a] = -1; val[a] = bk(a); end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1 reset: act rsp_valid=%b exp=0", rsp_valid);
    end

    // R1 R3: every word reads its backing value
    for (int a = 0; a < NW; a++) txn(0, a % 16, a, 0, "R1_R3 backing read");
    // R4 R6 R5: grant, forwarded read, forwarded registration per word
    for (int a = 0; a < NW; a++) begin
      txn(1, (a % 15) + 1, a, 0, "R4 grant");
      txn(0, 0, a, 0, "R6 forwarded read");
      txn(1, (a % 14) + 2 == (a % 15) + 1 ? 0 : (a % 14) + 2, a, 0, "R5 forward reg");
    end
    // R8 R11: owners return all words, then reads see written values
    for (int a = 0; a < NW; a++) txn(2, own[a], a, DATA_W'(16'hA000 + a * 3), "R8 writeback");
    for (int a = 0; a < NW; a++) txn(0, 7, a, 0, "R8_R11 read after writeback");
    // R5: chain of racing registrations forms a queue
    for (int s = 1; s <= 6; s++) txn(1, s, 5, 0, "R5 chain");
    // R7: owner re-registers
    txn(1, 6, 5, 0, "R7 owner re-register");
    // R9: non-owner write-back dropped, then owner still recorded
    txn(2, 3, 5, 16'hDEAD, "R9 non-owner writeback");
    txn(0, 9, 5, 0, "R9 state kept after drop");
    txn(2, 4, 9, 16'hBEEF, "R9 unowned writeback");
    txn(0, 4, 9, 0, "R9 data kept after drop");
    // R10: reserved op
    txn(3, 2, 5, 16'h1111, "R10 reserved op");
    txn(0, 2, 5, 0, "R10 state kept");
    txn(2, 6, 5, 16'h0C0C, "R8 owner writeback after chain");
    txn(0, 2, 5, 0, "R8 read back");
    // R11: back-to-back same word and same line, fresh line after reset values
    pair(1, 3, 8, 0, 0, 5, 8, 0, "R11 reg then read same word");
    pair(1, 4, 8, 0, 2, 4, 8, 16'h7777, "R11 reg then writeback same word");
    pair(0, 1, 8, 0, 1, 2, 9, 0, "R11 same line neighbour");
    pair(2, 2, 9, 16'h4242, 0, 1, 9, 0, "R11 writeback then read");
    pair(1, 9, 12, 0, 1, 10, 12, 0, "R5_R11 racing registrations");
    // R12 covered by data fields of forwards above
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule